// File: doc/BRIEF.md
# Profiling Control Register Access Arbiter

This block owns two 64-bit sampling-control registers, one belonging to the hypervisor privilege level and one to the kernel privilege level. It also decides the fate of every system-register read or write aimed at them. A request names the current privilege level (0 = user, 1 = kernel, 2 = hypervisor, 3 = firmware), the op1 selector of the register encoding, a read/write flag and write data. The block weighs that request against the firmware partition controls, the nested-virtualization bits, the host-mode flag, the fine-grained trap controls and the kernel-register trap bit.

Each request produces a registered response one cycle later. The response carries a status, an exception class for traps, and read data. An access can be completed on the register it names, completed on the other register, redirected to a memory slot (reported on a separate redirect output), refused as undefined, or trapped to the hypervisor or firmware level. Exception entry itself is left to the surrounding core.

Top module: `prof_ctl_access`

## Requirements
- R1: A request from privilege level 0 always completes with status UNDEFINED (status code 1).
- R2: A kernel-level (level 1) request with op1 = 3'b100 (hypervisor register) traps to the hypervisor (status 2) when nv_bits[0] is 1. Otherwise it is UNDEFINED.
- R3: The partition check fails when fw_present is 1 and any of these hold: part_en[0] is 0; part_en[1] differs from ns_bit; realm_present is 1 and part_ext differs from nse_bit. A failed check at level 2 gives UNDEFINED if undef_prio or sdd_undef is 1, and otherwise traps to firmware (status 3). A failed access leaves both registers unchanged.
- R4: A level-1 request with op1 = 3'b000 (kernel register) is decided by the first match in this order: (a) partition failure with undef_prio gives UNDEFINED; (b) a fine-grained trap gives TRAP_HYP; (c) hyp_enabled with kern_trap gives TRAP_HYP; (d) partition failure gives UNDEFINED if sdd_undef is set, else TRAP_FW; (e) nv_bits = 3'b111 redirects; (f) otherwise OK. A fine-grained trap needs hyp_enabled, fgt_present, (fgt_fw_en or !fw_present), and fgt_rd_trap for reads or fgt_wr_trap for writes.
- R5: A redirect completes with status OK. It asserts redir_valid with redir_offset = 12'h828 and redir_wdata = the write data. Read data is zero and neither register changes.
- R6: A level-2 request with op1 = 3'b000 that passes the partition check accesses the hypervisor register when host_mode is 1, and the kernel register otherwise.
- R7: A level-3 request with a valid op1 always completes with status OK on the register it names, whatever the other controls hold.
- R8: Only bits 0, 1, 3, 4, 5, 6 and 7 of either register are writable (mask 64'hFB). All other bits read as zero.
- R9: While buf_owner is nonzero, bits 1 and 0 of the hypervisor register read as zero without being cleared. The kernel register is not affected.
- R10: rsp_valid is high exactly in the cycle after a request. Both registers reset to zero. rsp_ec is 6'h18 on traps and zero otherwise. rsp_rdata is zero except for an OK read of a register.
- R11: A request whose op1 is neither 3'b000 nor 3'b100 completes with status UNDEFINED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_el | input | 2 | Privilege level of the requester |
| req_op1 | input | 3 | op1 field selecting the target register |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| fw_present | input | 1 | Firmware level implemented |
| part_en | input | 2 | Firmware partition enable/select bits |
| part_ext | input | 1 | Partition extension bit |
| realm_present | input | 1 | Realm security support present |
| ns_bit | input | 1 | Non-secure state bit |
| nse_bit | input | 1 | Extended security state bit |
| undef_prio | input | 1 | Partition failure is UNDEFINED ahead of other traps |
| sdd_undef | input | 1 | Partition failure is UNDEFINED instead of firmware trap |
| hyp_enabled | input | 1 | Hypervisor level enabled in current state |
| nv_bits | input | 3 | Nested-virtualization control bits |
| host_mode | input | 1 | Hypervisor running in host mode |
| fgt_present | input | 1 | Fine-grained trap feature present |
| fgt_fw_en | input | 1 | Firmware enable for fine-grained traps |
| fgt_rd_trap | input | 1 | Fine-grained trap on kernel register reads |
| fgt_wr_trap | input | 1 | Fine-grained trap on kernel register writes |
| kern_trap | input | 1 | Hypervisor trap bit for kernel register accesses |
| buf_owner | input | 2 | Profiling buffer owner control field |
| rsp_valid | output | 1 | Response valid |
| rsp_status | output | 2 | 0 OK, 1 UNDEFINED, 2 TRAP_HYP, 3 TRAP_FW |
| rsp_ec | output | 6 | Exception class, 6'h18 on traps |
| rsp_rdata | output | 64 | Read data |
| redir_valid | output | 1 | Access redirected to memory slot |
| redir_offset | output | 12 | Memory slot offset |
| redir_wdata | output | 64 | Data for a redirected write |

## Verification
On every cycle the assertions check the response timing and the exception class. They also check that level-0 requests are refused, that level-3 requests with a valid op1 succeed, that redirects always carry the fixed slot offset with an OK status, and that a register only changes when it is written. The ordering of the level-1 trap chain, the host-mode rerouting, the partition check's three failure conditions, and the read masks are shown only by the bench's directed scenarios. Each scenario sets one condition that should win over the others and reads the registers back through a level-3 access.

// File: rtl/prof_ctl_pkg.sv
package prof_ctl_pkg;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_UNDEF    = 2'd1,
    ST_TRAP_HYP = 2'd2,
    ST_TRAP_FW  = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    TG_NONE = 2'd0,
    TG_HYP  = 2'd1,
    TG_KERN = 2'd2,
    TG_MEM  = 2'd3
  } target_e;

  localparam logic [2:0] OP1_HYP  = 3'b100;
  localparam logic [2:0] OP1_KERN = 3'b000;

  localparam int unsigned BIT_EL0_EN  = 0;
  localparam int unsigned BIT_EL2_EN  = 1;
  localparam int unsigned BIT_CTX     = 3;
  localparam int unsigned BIT_PA      = 4;
  localparam int unsigned BIT_TS      = 5;
  localparam int unsigned BIT_TSEL_LO = 6;
  localparam int unsigned BIT_TSEL_HI = 7;
  localparam int unsigned FIELD_W     = 8;

  function automatic logic [FIELD_W-1:0] field_mask();
    logic [FIELD_W-1:0] m;
    m = '0;
    m[BIT_EL0_EN]  = 1'b1;
    m[BIT_EL2_EN]  = 1'b1;
    m[BIT_CTX]     = 1'b1;
    m[BIT_PA]      = 1'b1;
    m[BIT_TS]      = 1'b1;
    m[BIT_TSEL_LO] = 1'b1;
    m[BIT_TSEL_HI] = 1'b1;
    return m;
  endfunction

  // Partition check: true when the firmware level refuses the access.
  function automatic logic part_fail(input logic present, input logic [1:0] en,
                                     input logic ns, input logic realm,
                                     input logic ext, input logic nse);
    return present && (!en[0] || (en[1] != ns) || (realm && (ext != nse)));
  endfunction

  // Hypervisor register read view: the two enables vanish while the buffer
  // owner field is nonzero.
  function automatic logic [FIELD_W-1:0] hyp_view(input logic [FIELD_W-1:0] raw,
                                                  input logic owner_nz);
    logic [FIELD_W-1:0] v;
    v = raw;
    if (owner_nz) begin
      v[BIT_EL0_EN] = 1'b0;
      v[BIT_EL2_EN] = 1'b0;
    end
    return v;
  endfunction

endpackage

// File: rtl/prof_access_decide.sv
module prof_access_decide
  import prof_ctl_pkg::*;
(
  input  logic [1:0] el,
  input  logic [2:0] op1,
  input  logic       write,
  input  logic       fw_present,
  input  logic [1:0] part_en,
  input  logic       part_ext,
  input  logic       realm_present,
  input  logic       ns_bit,
  input  logic       nse_bit,
  input  logic       undef_prio,
  input  logic       sdd_undef,
  input  logic       hyp_enabled,
  input  logic [2:0] nv_bits,
  input  logic       host_mode,
  input  logic       fgt_present,
  input  logic       fgt_fw_en,
  input  logic       fgt_rd_trap,
  input  logic       fgt_wr_trap,
  input  logic       kern_trap,
  output status_e    status,
  output target_e    target
);

  logic sel_hyp, sel_kern, fw_fail, fgt_hit, ktrap_hit;

  assign sel_hyp   = (op1 == OP1_HYP);
  assign sel_kern  = (op1 == OP1_KERN);
  assign fw_fail   = part_fail(fw_present, part_en, ns_bit, realm_present, part_ext, nse_bit);
  assign fgt_hit   = hyp_enabled && fgt_present && (fgt_fw_en || !fw_present) &&
                     (write ? fgt_wr_trap : fgt_rd_trap);
  assign ktrap_hit = hyp_enabled && kern_trap;

  always_comb begin
    status = ST_UNDEF;
    target = TG_NONE;
    if (sel_hyp || sel_kern) begin
      unique case (el)
        2'd0: status = ST_UNDEF;
        2'd1: begin
          if (sel_hyp) begin
            status = nv_bits[0] ? ST_TRAP_HYP : ST_UNDEF;
          end else if (fw_fail && undef_prio) begin
            status = ST_UNDEF;
          end else if (fgt_hit || ktrap_hit) begin
            status = ST_TRAP_HYP;
          end else if (fw_fail) begin
            status = sdd_undef ? ST_UNDEF : ST_TRAP_FW;
          end else begin
            status = ST_OK;
            target = (nv_bits == 3'b111) ? TG_MEM : TG_KERN;
          end
        end
        2'd2: begin
          if (fw_fail) begin
            status = (undef_prio || sdd_undef) ? ST_UNDEF : ST_TRAP_FW;
          end else begin
            status = ST_OK;
            target = (sel_hyp || host_mode) ? TG_HYP : TG_KERN;
          end
        end
        default: begin
          status = ST_OK;
          target = sel_hyp ? TG_HYP : TG_KERN;
        end
      endcase
    end
  end

endmodule

// File: rtl/prof_ctl_regs.sv
module prof_ctl_regs
  import prof_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hyp,
  input  logic              wr_kern,
  input  logic [DATA_W-1:0] wdata,
  input  logic              owner_nz,
  output logic [DATA_W-1:0] hyp_rd,
  output logic [DATA_W-1:0] kern_rd
);

  localparam int unsigned NREG = 2;
  localparam int unsigned PAD_W = DATA_W - FIELD_W;
  localparam logic [FIELD_W-1:0] FMASK = field_mask();

  logic [NREG-1:0]    wr_en;
  logic [FIELD_W-1:0] fld_q [NREG];

  assign wr_en = {wr_kern, wr_hyp};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fld_q[g] <= '0;
      else if (wr_en[g]) fld_q[g] <= wdata[FIELD_W-1:0] & FMASK;
    end

    AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[g] |=> $stable(fld_q[g])); // R5
  end

  assign hyp_rd  = {{PAD_W{1'b0}}, hyp_view(fld_q[0], owner_nz)};
  assign kern_rd = {{PAD_W{1'b0}}, fld_q[1]};

endmodule

// File: rtl/prof_ctl_access.sv
module prof_ctl_access
  import prof_ctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned OFFSET_W = 12,
  parameter int unsigned EC_W     = 6,
  parameter logic [OFFSET_W-1:0] NV_SLOT  = 12'h828,
  parameter logic [EC_W-1:0]     TRAP_EC  = 6'h18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_el,
  input  logic [2:0]          req_op1,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                fw_present,
  input  logic [1:0]          part_en,
  input  logic                part_ext,
  input  logic                realm_present,
  input  logic                ns_bit,
  input  logic                nse_bit,
  input  logic                undef_prio,
  input  logic                sdd_undef,
  input  logic                hyp_enabled,
  input  logic [2:0]          nv_bits,
  input  logic                host_mode,
  input  logic                fgt_present,
  input  logic                fgt_fw_en,
  input  logic                fgt_rd_trap,
  input  logic                fgt_wr_trap,
  input  logic                kern_trap,
  input  logic [1:0]          buf_owner,
  output logic                rsp_valid,
  output logic [1:0]          rsp_status,
  output logic [EC_W-1:0]     rsp_ec,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                redir_valid,
  output logic [OFFSET_W-1:0] redir_offset,
  output logic [DATA_W-1:0]   redir_wdata
);

  status_e           dec_status;
  target_e           dec_target;
  logic              acc_ok, wr_hyp, wr_kern, is_redir;
  logic [DATA_W-1:0] hyp_rd, kern_rd, rd_sel;

  prof_access_decide u_decide (
    .el(req_el), .op1(req_op1), .write(req_write),
    .fw_present(fw_present), .part_en(part_en), .part_ext(part_ext),
    .realm_present(realm_present), .ns_bit(ns_bit), .nse_bit(nse_bit),
    .undef_prio(undef_prio), .sdd_undef(sdd_undef), .hyp_enabled(hyp_enabled),
    .nv_bits(nv_bits), .host_mode(host_mode), .fgt_present(fgt_present),
    .fgt_fw_en(fgt_fw_en), .fgt_rd_trap(fgt_rd_trap), .fgt_wr_trap(fgt_wr_trap),
    .kern_trap(kern_trap), .status(dec_status), .target(dec_target)
  );

  assign acc_ok   = req_valid && (dec_status == ST_OK);
  assign wr_hyp   = acc_ok && req_write && (dec_target == TG_HYP);
  assign wr_kern  = acc_ok && req_write && (dec_target == TG_KERN);
  assign is_redir = acc_ok && (dec_target == TG_MEM);

  prof_ctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hyp(wr_hyp), .wr_kern(wr_kern),
    .wdata(req_wdata), .owner_nz(buf_owner != 2'b00),
    .hyp_rd(hyp_rd), .kern_rd(kern_rd)
  );

  always_comb begin
    rd_sel = '0;
    if (acc_ok && !req_write) begin
      if (dec_target == TG_HYP)       rd_sel = hyp_rd;
      else if (dec_target == TG_KERN) rd_sel = kern_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_status   <= ST_OK;
      rsp_ec       <= '0;
      rsp_rdata    <= '0;
      redir_valid  <= 1'b0;
      redir_offset <= '0;
      redir_wdata  <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_status   <= req_valid ? dec_status : ST_OK;
      rsp_ec       <= (req_valid && dec_status[1]) ? TRAP_EC : '0;
      rsp_rdata    <= rd_sel;
      redir_valid  <= is_redir;
      redir_offset <= is_redir ? NV_SLOT : '0;
      redir_wdata  <= (is_redir && req_write) ? req_wdata : '0;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10
  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10
  AST_USER_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_el == 2'd0) |=> (rsp_status == ST_UNDEF)); // R1
  AST_FW_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_el == 2'd3 && (req_op1 == OP1_HYP || req_op1 == OP1_KERN))
      |=> (rsp_status == ST_OK && !redir_valid)); // R7
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status[1]) |-> (rsp_ec == TRAP_EC)); // R10
  AST_REDIR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_offset == NV_SLOT && rsp_status == ST_OK && rsp_rdata == '0)); // R5

endmodule

// File: tb/prof_ctl_access_test.sv
module prof_ctl_access_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_el = '0;
  logic [2:0]  req_op1 = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        fw_present, part_ext, realm_present, ns_bit, nse_bit;
  logic [1:0]  part_en, buf_owner;
  logic        undef_prio, sdd_undef, hyp_enabled, host_mode;
  logic [2:0]  nv_bits;
  logic        fgt_present, fgt_fw_en, fgt_rd_trap, fgt_wr_trap, kern_trap;
  logic        rsp_valid, redir_valid;
  logic [1:0]  rsp_status;
  logic [5:0]  rsp_ec;
  logic [63:0] rsp_rdata, redir_wdata;
  logic [11:0] redir_offset;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [1:0] S_OK = 2'd0, S_UND = 2'd1, S_TH = 2'd2, S_TF = 2'd3;
  localparam logic [2:0] HYP = 3'b100, KRN = 3'b000;

  always #4 clk = ~clk;

  prof_ctl_access uut (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic defaults();
    fw_present = 1; part_en = 2'b11; ns_bit = 1; part_ext = 0; nse_bit = 0;
    realm_present = 0; undef_prio = 0; sdd_undef = 0; hyp_enabled = 1;
    nv_bits = 3'b000; host_mode = 0; fgt_present = 0; fgt_fw_en = 0;
    fgt_rd_trap = 0; fgt_wr_trap = 0; kern_trap = 0; buf_owner = 2'b00;
  endtask

  // One request; outputs are sampled at the falling edge after the capturing edge.
  task automatic acc(input logic [1:0] el, input logic [2:0] op1,
                     input logic wr, input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1; req_el = el; req_op1 = op1; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic fw_read(input logic [2:0] op1, output logic [63:0] v);
    acc(2'd3, op1, 1'b0, '0);
    v = rsp_rdata;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk("R10 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    fw_read(HYP, v); chk("R10 hyp reset value", v, 64'd0);
    fw_read(KRN, v); chk("R10 kern reset value", v, 64'd0);
    @(negedge clk); chk("R10 single-cycle rsp_valid", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_fields();
    logic [63:0] v;
    acc(2'd3, HYP, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 write rdata zero", rsp_rdata, 64'd0);
    fw_read(HYP, v); chk("R8 hyp writable mask", v, 64'hFB);
    acc(2'd3, KRN, 1'b1, 64'hA5A5_0000_0000_0034);
    fw_read(KRN, v); chk("R8 kern writable mask", v, 64'h30);
    buf_owner = 2'b10;
    fw_read(HYP, v); chk("R9 hyp enables hidden", v, 64'hF8);
    acc(2'd3, KRN, 1'b1, 64'h3);
    fw_read(KRN, v); chk("R9 kern unaffected", v, 64'h3);
    buf_owner = 2'b00;
    fw_read(HYP, v); chk("R9 hyp enables kept", v, 64'hFB);
  endtask

  task automatic t_user();
    acc(2'd0, HYP, 1'b0, '0);
    chk("R1 user status", {62'd0, rsp_status}, {62'd0, S_UND});
    chk("R1 user rdata", rsp_rdata, 64'd0);
    chk("R10 undef class zero", {58'd0, rsp_ec}, 64'd0);
    acc(2'd1, 3'b011, 1'b0, '0);
    chk("R11 bad op1", {62'd0, rsp_status}, {62'd0, S_UND});
    acc(2'd3, 3'b101, 1'b0, '0);
    chk("R11 bad op1 firmware", {62'd0, rsp_status}, {62'd0, S_UND});
  endtask

  task automatic t_kern_to_hyp();
    nv_bits = 3'b001;
    acc(2'd1, HYP, 1'b0, '0);
    chk("R2 nv trap status", {62'd0, rsp_status}, {62'd0, S_TH});
    chk("R2 trap class", {58'd0, rsp_ec}, 64'h18);
    nv_bits = 3'b110;
    acc(2'd1, HYP, 1'b0, '0);
    chk("R2 no nv undef", {62'd0, rsp_status}, {62'd0, S_UND});
    defaults();
  endtask

  task automatic t_partition();
    logic [63:0] v;
    acc(2'd2, HYP, 1'b0, '0);
    chk("R3 pass status", {62'd0, rsp_status}, {62'd0, S_OK});
    chk("R3 pass rdata", rsp_rdata, 64'hFB);
    part_en = 2'b10;
    acc(2'd2, HYP, 1'b1, 64'h0);
    chk("R3 en0 clear traps fw", {62'd0, rsp_status}, {62'd0, S_TF});
    fw_read(HYP, v); chk("R3 failed write ignored", v, 64'hFB);
    sdd_undef = 1;
    acc(2'd2, HYP, 1'b0, '0);
    chk("R3 sdd undef", {62'd0, rsp_status}, {62'd0, S_UND});
    sdd_undef = 0; undef_prio = 1;
    acc(2'd2, KRN, 1'b0, '0);
    chk("R3 prio undef", {62'd0, rsp_status}, {62'd0, S_UND});
    defaults(); ns_bit = 0;
    acc(2'd2, HYP, 1'b0, '0);
    chk("R3 ns mismatch", {62'd0, rsp_status}, {62'd0, S_TF});
    defaults(); realm_present = 1; part_ext = 1;
    acc(2'd2, HYP, 1'b0, '0);
    chk("R3 realm ext mismatch", {62'd0, rsp_status}, {62'd0, S_TF});
    realm_present = 0;
    acc(2'd2, HYP, 1'b0, '0);
    chk("R3 ext ignored without realm", {62'd0, rsp_status}, {62'd0, S_OK});
    defaults(); fw_present = 0; part_en = 2'b00;
    acc(2'd2, HYP, 1'b0, '0);
    chk("R3 no firmware level", {62'd0, rsp_status}, {62'd0, S_OK});
    defaults();
  endtask

  task automatic t_chain();
    logic [63:0] v;
    fgt_present = 1; fgt_fw_en = 1; fgt_rd_trap = 1; kern_trap = 1;
    part_en = 2'b00; undef_prio = 1;
    acc(2'd1, KRN, 1'b0, '0);
    chk("R4a prio undef first", {62'd0, rsp_status}, {62'd0, S_UND});
    undef_prio = 0;
    acc(2'd1, KRN, 1'b0, '0);
    chk("R4b fine-grained read trap", {62'd0, rsp_status}, {62'd0, S_TH});
    acc(2'd1, KRN, 1'b1, 64'h8);
    chk("R4c kern_trap on write", {62'd0, rsp_status}, {62'd0, S_TH});
    kern_trap = 0;
    acc(2'd1, KRN, 1'b1, 64'h8);
    chk("R4d partition trap fw", {62'd0, rsp_status}, {62'd0, S_TF});
    sdd_undef = 1;
    acc(2'd1, KRN, 1'b1, 64'h8);
    chk("R4d partition sdd undef", {62'd0, rsp_status}, {62'd0, S_UND});
    fw_read(KRN, v); chk("R4 refused writes ignored", v, 64'h3);
    defaults(); fgt_present = 1; fgt_fw_en = 0; fgt_rd_trap = 1;
    acc(2'd1, KRN, 1'b0, '0);
    chk("R4b firmware gate off", {62'd0, rsp_status}, {62'd0, S_OK});
    fw_present = 0;
    acc(2'd1, KRN, 1'b0, '0);
    chk("R4b firmware absent", {62'd0, rsp_status}, {62'd0, S_TH});
    defaults(); hyp_enabled = 0; kern_trap = 1;
    acc(2'd1, KRN, 1'b0, '0);
    chk("R4c hyp disabled", {62'd0, rsp_status}, {62'd0, S_OK});
    chk("R4f plain read", rsp_rdata, 64'h3);
    defaults();
  endtask

  task automatic t_redirect();
    logic [63:0] v;
    nv_bits = 3'b111;
    acc(2'd1, KRN, 1'b1, 64'h21);
    chk("R5 redirect status", {62'd0, rsp_status}, {62'd0, S_OK});
    chk("R5 redirect valid", {63'd0, redir_valid}, 64'd1);
    chk("R5 redirect offset", {52'd0, redir_offset}, 64'h828);
    chk("R5 redirect data", redir_wdata, 64'h21);
    fw_read(KRN, v); chk("R5 kern unchanged", v, 64'h3);
    chk("R5 redirect cleared", {63'd0, redir_valid}, 64'd0);
    nv_bits = 3'b011;
    acc(2'd1, KRN, 1'b0, '0);
    chk("R5 partial nv no redirect", {63'd0, redir_valid}, 64'd0);
    defaults();
  endtask

  task automatic t_host();
    logic [63:0] v;
    host_mode = 1;
    acc(2'd2, KRN, 1'b1, 64'h01);
    fw_read(HYP, v); chk("R6 host write to hyp", v, 64'h01);
    fw_read(KRN, v); chk("R6 kern untouched", v, 64'h3);
    host_mode = 0;
    acc(2'd2, KRN, 1'b1, 64'hC0);
    fw_read(KRN, v); chk("R6 non-host write to kern", v, 64'hC0);
    fw_read(HYP, v); chk("R6 hyp untouched", v, 64'h01);
  endtask

  task automatic t_firmware();
    logic [63:0] v;
    part_en = 2'b00; undef_prio = 1; sdd_undef = 1; nv_bits = 3'b111;
    kern_trap = 1; fgt_present = 1; fgt_fw_en = 1; fgt_wr_trap = 1;
    acc(2'd3, KRN, 1'b1, 64'h10);
    chk("R7 firmware status", {62'd0, rsp_status}, {62'd0, S_OK});
    chk("R7 no redirect", {63'd0, redir_valid}, 64'd0);
    defaults();
    fw_read(KRN, v); chk("R7 firmware write landed", v, 64'h10);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fields();
    t_user();
    t_kern_to_hyp();
    t_partition();
    t_chain();
    t_redirect();
    t_host();
    t_firmware();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule